// File: doc/BRIEF.md
# Per-Channel Packed Receive Word Extractor

This block sits behind a receive link and holds incoming payload bytes for several logical channels. Each byte arrives tagged with a channel number. It is appended to that channel's own byte queue, so bytes from consecutive packets end up side by side with no padding, even when the packets arrive far apart in time. Software or a downstream engine then pulls the data back out as 32-bit words. Each request names a channel, and each response carries up to four bytes in the order they arrived, with the earliest byte in the least significant lane.

A request may stop partway through a packet or run on into the next one. The block keeps a read position for each channel, so the next request for that channel continues from where the previous one stopped. A response carries fewer than four bytes only when those are the last bytes held for the channel. The response also gives a valid-byte count, and a separate flag marks a read made to a channel that holds no data. If a channel queue is full, further bytes written to it are discarded, and a sticky per-channel flag records the loss.

The byte input never stalls: `in_ready` is tied high. Requests and responses use a valid/ready handshake with one response register between them. A request is taken only while that register is free or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` stays low.

Top module: `rxx_extractor`

## Requirements
- R1: After reset, `rsp_valid` is 0, `ovf_flags` is all zero, `req_ready` is 1 and `in_ready` is 1.
- R2: A request accepted while its channel holds four or more bytes returns the four oldest bytes little-endian, with the oldest in bits 7:0, `rsp_cnt` = 4 and `rsp_empty` = 0. The response appears one cycle after acceptance.
- R3: Bytes written to a channel in separate bursts, with idle cycles between them, are concatenated with no gap. One response word can hold bytes from both bursts.
- R4: Bytes written to different channels in interleaved order are kept apart. Each channel returns only its own bytes, in their own arrival order.
- R5: A channel holding 1, 2 or 3 bytes returns them with `rsp_cnt` equal to that number and the unused upper byte lanes zero. This is the only case in which `rsp_cnt` is between 1 and 3.
- R6: The read position of each channel persists between requests. A request that stops inside a burst is followed by one that resumes at the next unread byte, and it may continue into a later burst.
- R7: The 4-bit `req_be` input has no effect. A request made with `req_be` = 0 returns the same word and count as one made with all ones.
- R8: A request to a channel holding no bytes returns `rsp_data` = 0, `rsp_cnt` = 0 and `rsp_empty` = 1, and it leaves the channel's contents unchanged.
- R9: Each channel queue holds `DEPTH` (256) bytes. A byte written to a full channel is dropped and sets that channel's bit of `ovf_flags` (bit n for channel n). The bit stays set until reset and does not affect the other bits. The 256 stored bytes still read back unchanged.
- R10: While `rsp_valid` = 1 and `rsp_ready` = 0, `req_ready` is 0 and `rsp_data`, `rsp_cnt` and `rsp_empty` hold their values.
- R11: When a byte is written to a channel in the same cycle that a request for that channel is accepted, the response covers only the bytes stored before that cycle. The new byte is appended behind them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Always 1; the byte input never stalls |
| in_chan | input | CHW (2) | Channel of the incoming byte |
| in_byte | input | 8 | Incoming byte |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Read request can be taken this cycle |
| req_chan | input | CHW (2) | Channel to read |
| req_be | input | 4 | Byte enables, ignored |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Response word, oldest byte in bits 7:0 |
| rsp_cnt | output | 3 | Number of valid bytes, 0 to 4 |
| rsp_empty | output | 1 | Channel held no bytes at request time |
| ovf_flags | output | NCH (4) | Sticky per-channel drop flags |

## Verification
Two things can happen to one channel in the same cycle: a byte write appends to the queue, and an accepted request pops from its head. The bench provokes this by loading a channel with two bytes, then driving a write and a request for that channel on the same edge. The response must report only the two older bytes. A following request must return the byte written on that edge, alone, with a count of 1. Around the full-queue boundary the bench also drops bytes and then reads the queue out, which confirms that the dropped writes altered neither the stored bytes nor the head position.

// File: rtl/rxx_pkg.sv
package rxx_pkg;
  localparam int unsigned WORD_BYTES = 4;
  typedef logic [7:0] byte_t;
  typedef logic [2:0] bcnt_t;

  // bytes a single beat may take from a queue holding 'level' bytes
  function automatic bcnt_t beat_bytes(input int unsigned level);
    return (level >= WORD_BYTES) ? bcnt_t'(WORD_BYTES) : bcnt_t'(level);
  endfunction
endpackage

// File: rtl/rxx_chan_queue.sv
module rxx_chan_queue
  import rxx_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  byte_t       wr_data,
  input  logic        pop_en,
  output bcnt_t       avail,
  output logic [31:0] peek,
  output logic        ovf
);
  byte_t          mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  level;
  logic           full, wr_ok;
  bcnt_t          take;

  assign full  = (level == CW'(DEPTH));
  assign wr_ok = wr_en && !full;
  assign avail = beat_bytes(int'(level));
  assign take  = pop_en ? avail : '0;

  // head window: up to four bytes from the read pointer, zero past the data
  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    assign peek[8*i +: 8] = (bcnt_t'(i) < avail) ? mem[rd_ptr + AW'(i)] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + AW'(take);
      level  <= level + CW'(wr_ok) - CW'(take);
      if (wr_en && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rxx_word_pick.sv
module rxx_word_pick
  import rxx_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [CHW-1:0]   sel,
  input  logic             take,
  input  logic [NCH*32-1:0] peek_all,
  input  logic [NCH*3-1:0]  avail_all,
  output logic [31:0]      word,
  output bcnt_t            cnt,
  output logic [NCH-1:0]   pop_vec
);
  always_comb begin
    word = peek_all[sel*32 +: 32];
    cnt  = avail_all[sel*3 +: 3];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_pop
    assign pop_vec[c] = take && (sel == CHW'(c));
  end
endmodule

// File: rtl/rxx_extractor.sv
module rxx_extractor
  import rxx_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CHW-1:0] in_chan,
  input  logic [7:0]     in_byte,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [CHW-1:0] req_chan,
  input  logic [3:0]     req_be,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [31:0]    rsp_data,
  output logic [2:0]     rsp_cnt,
  output logic           rsp_empty,
  output logic [NCH-1:0] ovf_flags
);
  logic [NCH*32-1:0] peek_all;
  logic [NCH*3-1:0]  avail_all;
  logic [NCH-1:0]    pop_vec;
  logic [31:0]       pick_word;
  bcnt_t             pick_cnt;
  logic              accept;
  logic              be_unused;

  assign be_unused = ^req_be;          // byte enables carry no meaning here
  assign in_ready  = 1'b1;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    bcnt_t av;
    rxx_chan_queue #(.DEPTH(DEPTH)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid && (in_chan == CHW'(c))),
      .wr_data (in_byte),
      .pop_en  (pop_vec[c]),
      .avail   (av),
      .peek    (peek_all[c*32 +: 32]),
      .ovf     (ovf_flags[c])
    );
    assign avail_all[c*3 +: 3] = av;
  end

  rxx_word_pick #(.NCH(NCH)) u_pick (
    .sel       (req_chan),
    .take      (accept),
    .peek_all  (peek_all),
    .avail_all (avail_all),
    .word      (pick_word),
    .cnt       (pick_cnt),
    .pop_vec   (pop_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_cnt   <= '0;
      rsp_empty <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= pick_word;
      rsp_cnt   <= pick_cnt;
      rsp_empty <= (pick_cnt == '0);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rxx_extractor_chk.sv
module rxx_extractor_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [31:0]    rsp_data,
  input logic [2:0]     rsp_cnt,
  input logic           rsp_empty,
  input logic [NCH-1:0] ovf_flags
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_cnt) && $stable(rsp_empty))); // R10

  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R2

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_empty) |-> (rsp_data == 32'd0 && rsp_cnt == 3'd0)); // R8

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cnt <= 3'd4 && (rsp_empty == (rsp_cnt == 3'd0)))); // R2

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cnt != 3'd0 && rsp_cnt < 3'd4) |-> ((rsp_data >> {rsp_cnt, 3'b000}) == 32'd0)); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags))); // R9
endmodule

bind rxx_extractor rxx_extractor_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_cnt   (rsp_cnt),
  .rsp_empty (rsp_empty),
  .ovf_flags (ovf_flags)
);

// File: tb/tb_rxx_extractor.sv
`timescale 1ns/1ps
module tb_rxx_extractor;
  localparam int NCH = 4;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_chan = '0;
  logic [7:0]  in_byte = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = '0;
  logic [3:0]  req_be = 4'hF;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [2:0]  rsp_cnt;
  logic        rsp_empty;
  logic [3:0]  ovf_flags;

  always #2 clk = ~clk;

  rxx_extractor #(.NCH(NCH), .DEPTH(DEPTH)) dut (.*);

  typedef logic [7:0] byte_q_t[$];
  typedef struct { logic [31:0] d; logic [2:0] c; logic e; string tag; } exp_t;

  byte_q_t mdl [NCH];
  exp_t    expq[$];
  int      nchk = 0;
  int      nbad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask

  function automatic exp_t predict(int ch, string tag);
    exp_t e;
    int n;
    e.d = '0;
    n = (mdl[ch].size() >= 4) ? 4 : mdl[ch].size();
    for (int i = 0; i < n; i++) e.d[8*i +: 8] = mdl[ch].pop_front();
    e.c = 3'(n);
    e.e = (n == 0);
    e.tag = tag;
    return e;
  endfunction

  // drivers: called just after a rising edge, occupy one cycle
  task automatic put(int ch, logic [7:0] b);
    in_valid = 1'b1; in_chan = 2'(ch); in_byte = b;
    if (mdl[ch].size() < DEPTH) mdl[ch].push_back(b);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic get(int ch, logic [3:0] be, string tag);
    req_valid = 1'b1; req_chan = 2'(ch); req_be = be;
    expq.push_back(predict(ch, tag));
    @(posedge clk); #1;
    req_valid = 1'b0; req_be = 4'hF;
  endtask

  task automatic both(int ch, logic [7:0] b, string tag);
    req_valid = 1'b1; req_chan = 2'(ch);
    in_valid = 1'b1; in_chan = 2'(ch); in_byte = b;
    expq.push_back(predict(ch, tag));
    if (mdl[ch].size() < DEPTH) mdl[ch].push_back(b);
    @(posedge clk); #1;
    req_valid = 1'b0; in_valid = 1'b0;
  endtask

  // monitor: compares each consumed response with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) begin
        chk("R2 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk({e.tag, " data"}, rsp_data, e.d);
        chk({e.tag, " count"}, 32'(rsp_cnt), 32'(e.c));
        chk({e.tag, " empty"}, 32'(rsp_empty), 32'(e.e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 ovf_flags", 32'(ovf_flags), 32'd0);
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 word format
    put(0, 8'h11); put(0, 8'h22); put(0, 8'h33); put(0, 8'h44); put(0, 8'h55);
    get(0, 4'hF, "R2 first word");

    // R3 second burst after a gap packs behind the leftover byte
    repeat (3) @(posedge clk); #0;
    put(0, 8'h66); put(0, 8'h77); put(0, 8'h88);
    get(0, 4'hF, "R3 packed across bursts");

    // R4 interleaved channels
    for (int i = 0; i < 8; i++) begin
      put(1, 8'hA0 + 8'(i));
      put(2, 8'hB0 + 8'(i));
    end
    get(2, 4'hF, "R4 ch2 w0"); get(1, 4'hF, "R4 ch1 w0");
    get(2, 4'hF, "R4 ch2 w1"); get(1, 4'hF, "R4 ch1 w1");

    // R5 partial tail, then R8 empty
    put(1, 8'hC1); put(1, 8'hC2); put(1, 8'hC3);
    get(1, 4'hF, "R5 three-byte tail");
    get(1, 4'hF, "R8 empty after tail");

    // R6 resume mid-burst and run into the next burst
    for (int i = 0; i < 10; i++) put(2, 8'hD0 + 8'(i));
    get(2, 4'hF, "R6 first part");
    for (int i = 0; i < 5; i++) put(2, 8'hE0 + 8'(i));
    get(2, 4'hF, "R6 resume"); get(2, 4'hF, "R6 across bursts"); get(2, 4'hF, "R6 tail");

    // R7 byte enables ignored
    put(0, 8'h91); put(0, 8'h92); put(0, 8'h93); put(0, 8'h94);
    get(0, 4'h0, "R7 be zero");

    // R8 empty read leaves the channel untouched
    get(3, 4'hF, "R8 empty channel");
    put(3, 8'h5A);
    get(3, 4'hF, "R8 single byte after empty");

    // R11 write and read of one channel in the same cycle
    put(1, 8'h71); put(1, 8'h72);
    both(1, 8'h73, "R11 read sees older bytes");
    get(1, 4'hF, "R11 new byte follows");

    // R10 back-pressure
    for (int i = 0; i < 8; i++) put(0, 8'h20 + 8'(i));
    rsp_ready = 1'b0;
    get(0, 4'hF, "R10 held word");
    @(negedge clk);
    chk("R10 req_ready low", 32'(req_ready), 32'd0);
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd1);
    held = rsp_data;
    repeat (2) @(negedge clk);
    chk("R10 data held", rsp_data, held);
    chk("R10 req_ready still low", 32'(req_ready), 32'd0);
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    get(0, 4'hF, "R10 next word");

    // R9 overflow on channel 3
    for (int i = 0; i < DEPTH + 2; i++) put(3, 8'(i));
    @(negedge clk);
    chk("R9 ovf flags", 32'(ovf_flags), 32'h8);
    chk("R9 in_ready", 32'(in_ready), 32'd1);
    @(posedge clk); #1;
    for (int i = 0; i < DEPTH / 4; i++) get(3, 4'hF, "R9 stored bytes");
    get(3, 4'hF, "R9 drained");
    @(negedge clk);
    chk("R9 ovf sticky", 32'(ovf_flags), 32'h8);

    repeat (4) @(posedge clk);
    chk("R2 all responses seen", 32'(expq.size()), 32'd0);
    summary();
    $finish;
  end
endmodule